// File: doc/BRIEF.md
# Module Command Path with Selectable Register Stage

This block sits between a memory controller and the memory devices on a module. It forwards the command bus to every device: clock enable, chip select, the three command strobes, a 13-bit multiplexed address and a 2-bit bank select. A static select pin chooses one of two modes. In registered mode, every command bit is captured on a rising clock edge and reaches the devices one cycle later. In buffered mode, the bits pass straight through in the same cycle.

The block also reports the read latency the controller must use, as seen at the module edge. It equals the device CAS latency, plus one cycle in registered mode. From that latency it produces a read-data-valid strobe, timed from each read command seen at the host side.

The command bus has no valid/ready handshake and no back-pressure. An idle cycle is expressed as a NOP or a deselect, and every cycle's command is forwarded unconditionally.

Top module: `cmd_fwd_top`

## Requirements
- R1: With the mode pin sampled high, each device-side output in a cycle equals the host-side input of the previous cycle. In the first cycle after reset, the outputs show the idle value.
- R2: With the mode pin sampled low, each device-side output equals the host-side input in the same cycle.
- R3: `mod_cl_o` equals `dev_cl_i` + 1 in registered mode and equals `dev_cl_i` in buffered mode.
- R4: Clock enable, address (13 bits, wide enough for 13 row or 11 column bits) and bank select (2 bits) are forwarded bit for bit on the same timing as the command strobes. The single host clock-enable drives the shared device clock-enable.
- R5: While `rst_n` is low, the device side shows idle in both modes, whatever the host drives. Idle is clock enable 0, chip select, RAS, CAS and WE all 1, and address and bank 0. `rd_valid_o` is 0 during reset and in the first cycle after it.
- R6: The mode pin is sampled only while `rst_n` is low. A change after reset has no effect on forwarding or on `mod_cl_o` until the next reset.
- R7: A read is a host cycle with clock enable 1, chip select 0, RAS 1, CAS 0 and WE 1. A read presented in cycle c raises `rd_valid_o` for one cycle, in cycle c + `mod_cl_o`. If `mod_cl_o` is 0, no strobe is produced.
- R8: Reads in consecutive cycles each produce their own strobe, so the strobes come back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; mode pin sampled here |
| reg_sel | input | 1 | Mode pin: 1 registered, 0 buffered |
| dev_cl_i | input | 3 | Device CAS latency in cycles |
| h_cke | input | 1 | Host clock enable |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ras_n | input | 1 | Host row strobe, active low |
| h_cas_n | input | 1 | Host column strobe, active low |
| h_we_n | input | 1 | Host write enable, active low |
| h_ba | input | 2 | Host bank select |
| h_addr | input | 13 | Host multiplexed address |
| d_cke | output | 1 | Shared device clock enable |
| d_cs_n | output | 1 | Device chip select |
| d_ras_n | output | 1 | Device row strobe |
| d_cas_n | output | 1 | Device column strobe |
| d_we_n | output | 1 | Device write enable |
| d_ba | output | 2 | Device bank select |
| d_addr | output | 13 | Device address |
| mod_cl_o | output | 4 | Read latency seen at the module edge |
| rd_valid_o | output | 1 | Read data valid strobe |

## Verification
Forwarding of a new command and the return strobe of an earlier read can land in the same cycle. This is certain whenever reads are spaced by less than the module latency. The bench provokes it with reads every third cycle plus a back-to-back pair, mixed with pseudo-random traffic. Every device latency from 0 to 7 is swept in both modes. In each cycle, the bench judges the device bus against the current or previous host word and the strobe against the read history delayed by the expected latency, and it does both independently.

// File: rtl/cmd_fwd_pkg.sv
package cmd_fwd_pkg;
  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic logic is_read(ctl_t c);
    return c.cke && !c.cs_n && c.ras_n && !c.cas_n && c.we_n;
  endfunction
endpackage

// File: rtl/cmd_stage.sv
module cmd_stage #(
  parameter int W = 8,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_mode,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= IDLE;
    else        q <= d_i;
  end

  always_comb begin
    if (!rst_n)        d_o = IDLE;
    else if (reg_mode) d_o = q;
    else               d_o = d_i;
  end

  // R1: registered mode delays the whole bus by exactly one edge
  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && $past(rst_n)) |-> (d_o == $past(d_i)));
endmodule

// File: rtl/lat_calc.sv
module lat_calc #(
  parameter int CL_W = 3,
  localparam int MCL_W = CL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_mode,
  input  logic [CL_W-1:0]  dev_cl,
  output logic [MCL_W-1:0] mod_cl
);
  always_comb mod_cl = {1'b0, dev_cl} + MCL_W'(reg_mode);

  // R3/R6: with a steady device latency the reported latency never moves after reset
  a_r3_lat_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(dev_cl)) |-> $stable(mod_cl));
endmodule

// File: rtl/rd_strobe.sv
module rd_strobe #(
  parameter int CL_W = 3,
  localparam int MCL_W = CL_W + 1,
  localparam int DEPTH = 2 ** CL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic [MCL_W-1:0] lat,
  output logic             strobe
);
  logic [DEPTH-1:0] sr;
  logic [MCL_W-1:0] idx;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= rd_hit;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], rd_hit};
      end
    end
  endgenerate

  always_comb begin
    idx    = lat - 1'b1;
    strobe = 1'b0;
    if (lat != '0 && lat <= MCL_W'(DEPTH)) strobe = sr[idx[CL_W-1:0]];
  end

  // R5: the strobe stays low in the first cycle out of reset
  a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !strobe);
  // R7: a zero latency never yields a strobe
  a_r7_zero_lat: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == '0) |-> !strobe);
endmodule

// File: rtl/cmd_fwd_top.sv
module cmd_fwd_top #(
  parameter int ROW_W = 13,
  parameter int COL_W = 11,
  parameter int BA_W  = 2,
  parameter int CL_W  = 3,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int MCL_W  = CL_W + 1,
  localparam int CTL_W  = $bits(cmd_fwd_pkg::ctl_t),
  localparam int BUS_W  = CTL_W + BA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic [CL_W-1:0]   dev_cl_i,
  input  logic              h_cke,
  input  logic              h_cs_n,
  input  logic              h_ras_n,
  input  logic              h_cas_n,
  input  logic              h_we_n,
  input  logic [BA_W-1:0]   h_ba,
  input  logic [ADDR_W-1:0] h_addr,
  output logic              d_cke,
  output logic              d_cs_n,
  output logic              d_ras_n,
  output logic              d_cas_n,
  output logic              d_we_n,
  output logic [BA_W-1:0]   d_ba,
  output logic [ADDR_W-1:0] d_addr,
  output logic [MCL_W-1:0]  mod_cl_o,
  output logic              rd_valid_o
);
  import cmd_fwd_pkg::*;

  localparam logic [BUS_W-1:0] BUS_IDLE = {CTL_IDLE, {BA_W{1'b0}}, {ADDR_W{1'b0}}};

  logic mode_q;
  ctl_t h_ctl, d_ctl;
  logic [BUS_W-1:0] h_bus, d_bus;
  logic rd_hit;

  // mode pin is only looked at while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= reg_sel;
  end

  always_comb begin
    h_ctl = '{cke: h_cke, cs_n: h_cs_n, ras_n: h_ras_n, cas_n: h_cas_n, we_n: h_we_n};
    h_bus = {h_ctl, h_ba, h_addr};
    rd_hit = rst_n && is_read(h_ctl);
  end

  cmd_stage #(.W(BUS_W), .IDLE(BUS_IDLE)) u_stage (
    .clk(clk), .rst_n(rst_n), .reg_mode(mode_q), .d_i(h_bus), .d_o(d_bus)
  );

  always_comb begin
    {d_ctl, d_ba, d_addr} = d_bus;
    d_cke   = d_ctl.cke;
    d_cs_n  = d_ctl.cs_n;
    d_ras_n = d_ctl.ras_n;
    d_cas_n = d_ctl.cas_n;
    d_we_n  = d_ctl.we_n;
  end

  lat_calc #(.CL_W(CL_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .reg_mode(mode_q), .dev_cl(dev_cl_i), .mod_cl(mod_cl_o)
  );

  rd_strobe #(.CL_W(CL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .lat(mod_cl_o), .strobe(rd_valid_o)
  );

  // R2: buffered mode shows host pins at device pins in the same cycle
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (d_cs_n == h_cs_n && d_cke == h_cke && d_addr == h_addr && d_ba == h_ba));
  // R6: the sampled mode cannot move outside reset
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: tb/sim_cmd_fwd_top.sv
module sim_cmd_fwd_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, reg_sel;
  logic [2:0] dev_cl;
  logic [19:0] stim, dbus;
  logic h_cke, h_cs_n, h_ras_n, h_cas_n, h_we_n;
  logic [1:0] h_ba;
  logic [12:0] h_addr;
  logic d_cke, d_cs_n, d_ras_n, d_cas_n, d_we_n;
  logic [1:0] d_ba;
  logic [12:0] d_addr;
  logic [3:0] mod_cl;
  logic rd_valid;

  assign {h_cke, h_cs_n, h_ras_n, h_cas_n, h_we_n, h_ba, h_addr} = stim;
  assign dbus = {d_cke, d_cs_n, d_ras_n, d_cas_n, d_we_n, d_ba, d_addr};

  cmd_fwd_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .dev_cl_i(dev_cl),
    .h_cke(h_cke), .h_cs_n(h_cs_n), .h_ras_n(h_ras_n), .h_cas_n(h_cas_n), .h_we_n(h_we_n),
    .h_ba(h_ba), .h_addr(h_addr),
    .d_cke(d_cke), .d_cs_n(d_cs_n), .d_ras_n(d_ras_n), .d_cas_n(d_cas_n), .d_we_n(d_we_n),
    .d_ba(d_ba), .d_addr(d_addr), .mod_cl_o(mod_cl), .rd_valid_o(rd_valid)
  );

  localparam logic [19:0] IDLE = {1'b0, 4'b1111, 2'b00, 13'd0};
  int checks = 0, fails = 0;
  logic [31:0] seed = 32'h1ACE_B00C;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic rd_of(logic [19:0] s);
    return s[19] && !s[18] && s[17] && !s[16] && s[15];
  endfunction

  function automatic logic [19:0] gen(int c);
    logic [19:0] s;
    seed = seed * 32'd1664525 + 32'd1013904223;
    s = seed[31:12];
    if (c % 3 == 1 || c == 20 || c == 21) s[19:15] = 5'b10101;
    return s;
  endfunction

  task automatic run(bit mode, int cl, bit flip);
    logic [19:0] prev;
    bit rdh[0:63];
    int mcl;
    reg_sel = mode;
    dev_cl  = 3'(cl);
    rst_n   = 1'b0;
    repeat (3) begin
      @(negedge clk);
      stim = gen(0);
    end
    #1;
    chk("R5 bus", 32'(dbus), 32'(IDLE));
    chk("R5 strobe", 32'(rd_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mcl = cl + int'(mode);
    prev = IDLE;
    for (int c = 0; c < 40; c++) begin
      if (c > 0) @(negedge clk);
      stim = gen(c);
      if (flip && c == 10) reg_sel = ~mode;
      rdh[c] = rd_of(stim);
      #1;
      // R4 covered: every bit of cke, bank and address is in the compared word
      if (mode) chk("R1 R4", 32'(dbus), 32'(prev));
      else      chk("R2 R4", 32'(dbus), 32'(stim));
      // R7 R8: strobe equals the read history shifted by the module latency
      chk("R7 R8", 32'(rd_valid), (mcl > 0 && c >= mcl) ? 32'(rdh[c - mcl]) : 0);
      if (c == 0 || c == 30) chk(flip ? "R6 R3" : "R3", 32'(mod_cl), 32'(mcl));
      prev = stim;
    end
    @(negedge clk);
    stim = IDLE;
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; dev_cl = 3'd0; stim = IDLE;
    for (int m = 0; m < 2; m++)
      for (int cl = 0; cl < 8; cl++)
        run(m[0], cl, 1'b0);
    run(1'b1, 3, 1'b1);
    run(1'b0, 3, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule